// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the opening bytes of each incoming Ethernet frame and decides whether the frame is for this station. Bytes arrive one per cycle with a valid flag. A start marker tags the first byte of a frame and an end marker tags its last byte. The first six bytes form the destination address. One cycle after the sixth byte arrives, the block raises a one-cycle verdict strobe that carries an accept or reject flag. The payload itself passes by untouched, and a downstream buffer uses the verdict to keep or drop the frame.

Rules are applied in a fixed order:
1. If receive is disabled, the frame is rejected.
2. If promiscuous mode is on, the frame is accepted.
3. If the address equals the programmed station address, the frame is accepted.
4. If the address is all ones (broadcast), the frame is accepted.
5. Otherwise, if hash filtering is on, the address is hashed with a byte-wide CRC-32, and the frame is accepted when the selected bit of a 64-bit table is set. If hash filtering is off, the frame is rejected.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is held and on the first cycle after reset, `verdictValid` is low.
- R2: A frame starts with a valid byte that has `byteSof` high; that byte is address byte 0. Exactly one verdict pulse follows each frame, on the cycle after the sixth address byte is taken. Valid bytes outside a frame, and bytes after the verdict, produce no pulse.
- R3: If `rxEnable` is low when the sixth address byte arrives, the verdict is reject.
- R4: If `promiscEnable` is high with `rxEnable` high, the verdict is accept for any address.
- R5: The address is compared with `stationAddr`, where address byte n matches bits [47-8n:40-8n]. A full match is accepted.
- R6: An all-ones destination address is accepted as broadcast.
- R7: When `hashEnable` is high and neither the station address nor broadcast matched, the block computes a hash index. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, takes each address byte least significant bit first, and applies no final inversion. The index is CRC bits 31:26. Index bits 5:4 pick the 16-bit word k, held in `hashTable` bits [16k+15:16k], and index bits 3:0 pick the bit in that word, so the tested bit is `hashTable[index]`. The frame is accepted only when that bit is 1.
- R8: With `hashEnable` low, an address that is neither the station address nor broadcast is rejected.
- R9: A frame whose `byteEof` comes before its sixth byte gets a reject verdict on the cycle after that last byte.
- R10: A `byteSof` byte arriving inside an unfinished frame restarts address collection at byte 0. Only the new frame gets a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is present this cycle |
| byteData | input | 8 | Frame byte |
| byteSof | input | 1 | First byte of a frame |
| byteEof | input | 1 | Last byte of a frame |
| rxEnable | input | 1 | Receive enable |
| promiscEnable | input | 1 | Accept every address |
| hashEnable | input | 1 | Enable the multicast hash check |
| stationAddr | input | 48 | Station address, byte 0 in the top octet |
| hashTable | input | 64 | Hash bit table, word k in bits [16k+15:16k] |
| verdictValid | output | 1 | One-cycle verdict strobe |
| verdictAccept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The bench computes the hash index with its own CRC model. It then sets only that table bit, and after that clears only that bit. A design that reversed the word order or the bit order inside a byte would flip one of those two verdicts. Short frames, restarts in the middle of a frame, and bytes outside any frame are sent so that a design that dropped the early-end reject, merged two address fields, or counted stray bytes would give a missing, extra or wrongly timed pulse. The bench also checks the priority cases: receive disabled overrides promiscuous mode, and broadcast is accepted with hashing off. Each verdict's arrival cycle is compared against the edge that took the sixth byte, which catches any extra pipeline stage.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef struct packed {
    logic start;   // byte 0 of a new frame
    logic take;    // shift byte into history and CRC
    logic decide;  // last address byte: register verdict
    logic abort;   // frame ended early: register reject
  } filtStrobe_t;

  // Reflected CRC-32 update over one byte, LSB first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] c;
    c = crcIn;
    for (int j = 0; j < 8; j++) begin
      if (c[0] ^ dataIn[j]) c = (c >> 1) ^ CRC_POLY;
      else c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_dest_filter_ctrl.sv
module rx_dest_filter_ctrl
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteSof,
  input  logic        byteEof,
  output filtStrobe_t strb
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_DONE} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    strb = '0;
    if (byteValid) begin
      if (byteSof) begin
        strb.start = 1'b1;
        strb.take  = 1'b1;
        strb.abort = byteEof;
      end else if (state == ST_COLLECT) begin
        strb.take = 1'b1;
        if (byteCnt == LAST_IDX) strb.decide = 1'b1;
        else if (byteEof) strb.abort = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
    end else if (byteValid) begin
      if (byteSof) begin
        state   <= byteEof ? ST_IDLE : ST_COLLECT;
        byteCnt <= CNT_W'(1);
      end else begin
        case (state)
          ST_COLLECT: begin
            if (byteCnt == LAST_IDX) state <= ST_DONE;
            else if (byteEof) state <= ST_IDLE;
            byteCnt <= byteCnt + CNT_W'(1);
          end
          ST_DONE: if (byteEof) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_dest_filter_dpath.sv
module rx_dest_filter_dpath
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  filtStrobe_t                 strb,
  input  logic [7:0]                  byteData,
  input  logic                        rxEnable,
  input  logic                        promiscEnable,
  input  logic                        hashEnable,
  input  logic [8*ADDR_BYTES-1:0]     stationAddr,
  input  logic [(1<<HASH_BITS)-1:0]   hashTable,
  output logic                        verdictValid,
  output logic                        verdictAccept
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int HIST_W = ADDR_W - 8;

  logic [HIST_W-1:0]    addrHist;
  logic [31:0]          crcReg;
  logic [31:0]          crcNext;
  logic [ADDR_W-1:0]    fullAddr;
  logic [ADDR_BYTES-1:0] byteHit;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 stationHit;
  logic                 bcastHit;
  logic                 hashHit;
  logic                 acceptNow;

  assign crcNext  = crcByte(strb.start ? CRC_INIT : crcReg, byteData);
  assign fullAddr = {addrHist, byteData};
  assign hashIdx  = crcNext[31 -: HASH_BITS];

  // Per-byte station compare: byte n sits in the n-th octet from the top
  for (genvar n = 0; n < ADDR_BYTES; n++) begin : g_cmp
    assign byteHit[n] = fullAddr[ADDR_W-1-8*n -: 8] == stationAddr[ADDR_W-1-8*n -: 8];
  end

  assign stationHit = &byteHit;
  assign bcastHit   = &fullAddr;
  assign hashHit    = hashEnable & hashTable[hashIdx];
  assign acceptNow  = rxEnable & (promiscEnable | stationHit | bcastHit | hashHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHist      <= '0;
      crcReg        <= CRC_INIT;
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end else begin
      if (strb.take) begin
        addrHist <= fullAddr[HIST_W-1:0];
        crcReg   <= crcNext;
      end
      verdictValid  <= strb.decide | strb.abort;
      verdictAccept <= strb.decide & acceptNow;
    end
  end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      byteValid,
  input  logic [7:0]                byteData,
  input  logic                      byteSof,
  input  logic                      byteEof,
  input  logic                      rxEnable,
  input  logic                      promiscEnable,
  input  logic                      hashEnable,
  input  logic [8*ADDR_BYTES-1:0]   stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  output logic                      verdictValid,
  output logic                      verdictAccept
);
  filtStrobe_t strb;

  rx_dest_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .byteSof(byteSof), .byteEof(byteEof), .strb(strb)
  );

  rx_dest_filter_dpath #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .rxEnable(rxEnable), .promiscEnable(promiscEnable), .hashEnable(hashEnable),
    .stationAddr(stationAddr), .hashTable(hashTable),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        byteValid,
  input logic [7:0]  byteData,
  input logic        rxEnable,
  input logic        promiscEnable,
  input filtStrobe_t strb,
  input logic        verdictValid,
  input logic        verdictAccept
);
  localparam int HIST_W = 8 * ADDR_BYTES - 8;

  logic [HIST_W-1:0] chkHist;
  always_ff @(posedge clk) begin
    if (!rstN) chkHist <= '0;
    else if (byteValid) chkHist <= {chkHist[HIST_W-9:0], byteData};
  end

  assert_decide_gives_verdict_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |=> verdictValid);
  assert_accept_only_with_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    verdictAccept |-> verdictValid);
  assert_disabled_rejects_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !rxEnable) |=> !verdictAccept);
  assert_promisc_accepts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && rxEnable && promiscEnable) |=> verdictAccept);
  assert_bcast_accepts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && rxEnable && (&{chkHist, byteData})) |=> verdictAccept);
  assert_short_rejects_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (verdictValid && !verdictAccept));

endmodule

bind rx_dest_filter rx_dest_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .rxEnable(rxEnable), .promiscEnable(promiscEnable), .strb(strb),
  .verdictValid(verdictValid), .verdictAccept(verdictAccept)
);

// File: tb/sim_rx_dest_filter.sv
module sim_rx_dest_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteSof = 1'b0;
  logic byteEof = 1'b0;
  logic rxEnable = 1'b0;
  logic promiscEnable = 1'b0;
  logic hashEnable = 1'b0;
  logic [47:0] stationAddr = 48'h0250_A1B2_C3D4;
  logic [63:0] hashTable = '0;
  logic verdictValid;
  logic verdictAccept;

  int testsRun = 0;
  int testsFailed = 0;
  int posCount = 0;
  int vCount = 0;
  int vCycle = -1;
  logic vAcc = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rx_dest_filter u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteSof(byteSof), .byteEof(byteEof), .rxEnable(rxEnable),
    .promiscEnable(promiscEnable), .hashEnable(hashEnable),
    .stationAddr(stationAddr), .hashTable(hashTable),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );

  always @(posedge clk) posCount <= posCount + 1;

  always @(negedge clk) begin
    if (rstN && verdictValid) begin
      vCount <= vCount + 1;
      vAcc   <= verdictAccept;
      vCycle <= posCount;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Bench model of the hash index: reflected CRC, LSB first, no final inversion
  function automatic int hashIndex(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return int'(c[31:26]);
  endfunction

  task automatic driveByte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    byteValid = 1'b1; byteData = d; byteSof = s; byteEof = e;
  endtask

  task automatic idleBus();
    @(negedge clk);
    byteValid = 1'b0; byteSof = 1'b0; byteEof = 1'b0;
  endtask

  // Send a frame of len bytes and check for exactly one verdict at the right cycle
  task automatic sendFrame(input logic [47:0] addr, input int len, input logic expAcc, input string req);
    int expCycle = -1;
    int lastAddr = (len < 6) ? len - 1 : 5;
    vCount = 0;
    for (int i = 0; i < len; i++) begin
      driveByte((i < 6) ? addr[47-8*i -: 8] : 8'(i), i == 0, i == len - 1);
      if (i == lastAddr) expCycle = posCount + 1;
    end
    idleBus();
    repeat (4) @(negedge clk);
    check(vCount == 1, {req, " verdict count"}, vCount, 1);
    check(vCycle == expCycle, {req, " verdict cycle"}, vCycle, expCycle);
    check(vAcc == expAcc, {req, " verdict value"}, int'(vAcc), int'(expAcc));
  endtask

  task automatic testReset();
    check(verdictValid == 1'b0, "R1 reset verdictValid", int'(verdictValid), 0);
  endtask

  task automatic testRxDisabled();
    rxEnable = 1'b0; promiscEnable = 1'b1;
    sendFrame(stationAddr, 10, 1'b0, "R3 disabled rejects");
    promiscEnable = 1'b0; rxEnable = 1'b1;
  endtask

  task automatic testPromisc();
    promiscEnable = 1'b1;
    sendFrame(48'h1234_5678_9ABC, 12, 1'b1, "R4 promiscuous");
    promiscEnable = 1'b0;
  endtask

  task automatic testStation();
    sendFrame(stationAddr, 8, 1'b1, "R5 station match");
    sendFrame(stationAddr ^ 48'h0000_0000_0001, 8, 1'b0, "R5 last byte differs");
    sendFrame(stationAddr ^ 48'h0100_0000_0000, 8, 1'b0, "R5 first byte differs");
  endtask

  task automatic testBroadcast();
    sendFrame(48'hFFFF_FFFF_FFFF, 6, 1'b1, "R6 broadcast");
  endtask

  task automatic testHash();
    logic [47:0] mc = 48'h0100_5E00_00FB;
    int idx = hashIndex(mc);
    hashEnable = 1'b1;
    hashTable = 64'd1 << idx;
    sendFrame(mc, 9, 1'b1, "R7 hash bit set");
    hashTable = ~(64'd1 << idx);
    sendFrame(mc, 9, 1'b0, "R7 hash bit clear");
    mc = 48'h3333_0000_0001;
    idx = hashIndex(mc);
    hashTable = 64'd1 << idx;
    sendFrame(mc, 7, 1'b1, "R7 second address");
    hashEnable = 1'b0;
  endtask

  task automatic testHashOff();
    hashTable = '1;
    sendFrame(48'h0100_5E00_0001, 8, 1'b0, "R8 hash off rejects");
    hashTable = '0;
  endtask

  task automatic testShort();
    promiscEnable = 1'b1;
    sendFrame(48'hFFFF_FFFF_FFFF, 4, 1'b0, "R9 short frame");
    sendFrame(48'hFFFF_FFFF_FFFF, 1, 1'b0, "R9 single byte frame");
    promiscEnable = 1'b0;
  endtask

  task automatic testStray();
    vCount = 0;
    for (int i = 0; i < 8; i++) driveByte(8'hFF, 1'b0, i == 7);
    idleBus();
    repeat (3) @(negedge clk);
    check(vCount == 0, "R2 bytes outside frame", vCount, 0);
  endtask

  task automatic testRestart();
    vCount = 0;
    driveByte(8'hFF, 1'b1, 1'b0);
    driveByte(8'hFF, 1'b0, 1'b0);
    driveByte(8'hFF, 1'b0, 1'b0);
    check(vCount == 0, "R10 partial frame no verdict", vCount, 0);
    // restart: the new frame carries a non-matching address and must be rejected
    sendFrame(48'hFFFF_FF00_0000, 8, 1'b0, "R10 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    rxEnable = 1'b1;
    testRxDisabled();
    testPromisc();
    testStation();
    testBroadcast();
    testHash();
    testHashOff();
    testShort();
    testStray();
    testRestart();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule